// File: doc/BRIEF.md
# Programmable low-power sequencer

This block sits beside one processor core and puts it into a low-power state. Software writes a short program of byte-wide commands into a small sequence store. It then writes an enable bit and a start index into a control register. When the core executes wait-for-interrupt and raises its indication, the sequencer runs commands from the chosen index. Each command drives four low-power control lines, such as clock gate, retention and power switch. A command may stall the sequencer until a wake interrupt arrives, and it may pause for a programmable number of steps. The byte `0x0F` ends the program, releases the core and returns the sequencer to idle.

Several programs can sit back to back in the store, and each is selected only by its start index. A configuration divider sets how many clock cycles one interpreter step takes. A status register reports the current index and whether the sequencer is busy, waiting for a wake interrupt, or stopped with an error.

The interpreter has four states. `S_IDLE` waits for a trigger. `S_RUN` executes one command per step. `S_WAKE` stalls for the wake interrupt. `S_DELAY` counts down a delay.

The transitions are these:
- `S_IDLE`→`S_RUN` on a rising wait-for-interrupt with the enable bit set.
- `S_RUN`→`S_IDLE` on the end marker, or when the index passes the last entry.
- `S_RUN`→`S_WAKE` when a command has bit 7 set.
- `S_RUN`→`S_DELAY` when a command selects a delay and does not wait.
- `S_WAKE`→`S_DELAY` or `S_WAKE`→`S_RUN` when the wake interrupt arrives, depending on whether a delay is pending.
- `S_DELAY`→`S_RUN` when the count expires.

Top module: `lp_sequencer`

## Requirements
- R1: Control register bit 0 is the enable. While it is 0, a rising wait-for-interrupt starts nothing: `core_hold` stays 0 and `lp_ctrl` stays 0.
- R2: Control register bits 10:4 hold the 7-bit start index, which is the first command executed after a trigger. Only bits 0 and 10:4 of the control register are stored, and the other bits read as 0.
- R3: The sequence store is 8 words at byte addresses 0x80 to 0x9C. Command index `4*w+b` is byte `b` of word `w`, with byte 0 in bits 7:0.
- R4: Executing command `0x0F` clears `lp_ctrl` to 0, drops `core_hold` and returns to idle, leaving the index on the end marker.
- R5: A program may start in the middle of a word, right after another program's end marker, and runs from that index only.
- R6: Only a rising edge of `core_wfi` triggers the sequencer. Holding `core_wfi` high after a program ends does not start it again.
- R7: For any other command, bits 3:0 drive `lp_ctrl`. If bit 7 is set, the sequencer then stalls with `lp_ctrl` unchanged until `wake_irq` is high, and status bit 9 reads 1 during the stall.
- R8: A nonzero value `k` in command bits 6:4 selects delay field `k` of the delay register (0x34), which is bits `4k-1:4k-4`. The next command waits that many extra steps, and the delay starts after any wake stall.
- R9: Configuration register (0x08) bits 7:0 hold a divider `d`. The interpreter makes one step every `d+1` clock cycles.
- R10: The status register (0x0C) holds the current index in bits 6:0, busy in bit 8, waiting-for-wake in bit 9 and error in bit 10. All other bits are 0.
- R11: Reaching an index of 32 or more without an end marker stops the sequencer and sets status bit 10. It also clears `lp_ctrl` and drops `core_hold`. The error flag clears on the next trigger.
- R12: While the sequencer is busy, writes to the control register and to the sequence store are ignored. Writes to the other registers still take effect.
- R13: A read (`bus_valid`=1, `bus_write`=0) returns the register data on `bus_rdata` in the following cycle. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| core_wfi | input | 1 | Core has executed wait-for-interrupt |
| wake_irq | input | 1 | Wake interrupt |
| lp_ctrl | output | 4 | Low-power control lines from the current command |
| core_hold | output | 1 | Core held in low-power mode while 1 |

## Verification
The hardest situation to reach is a write that arrives while a program is running. To open a wide enough window, the bench triggers a program whose second command waits for a wake interrupt, and it keeps the wake interrupt low. It then writes the control register and the first store word during the stall, releases the wake, and reads both back once the core is released. Exact step spacing is checked with the divider set to 2, and the index overrun is forced by a program that fills the store's last two words with no end marker.

// File: rtl/lpseq_pkg.sv
package lpseq_pkg;
    localparam int ADDR_W     = 12;
    localparam int DATA_W     = 32;
    localparam int IDX_W      = 7;
    localparam int SEQ_WORDS  = 8;
    localparam int SEQ_BYTES  = SEQ_WORDS * 4;
    localparam int FETCH_W    = $clog2(SEQ_BYTES);
    localparam int DIV_W      = 8;
    localparam int DLY_W      = 4;
    localparam int DLY_FIELDS = 7;
    localparam int CTRL_W     = 4;

    localparam logic [ADDR_W-1:0] ADDR_CFG = 12'h008;
    localparam logic [ADDR_W-1:0] ADDR_STS = 12'h00C;
    localparam logic [ADDR_W-1:0] ADDR_CTL = 12'h030;
    localparam logic [ADDR_W-1:0] ADDR_DLY = 12'h034;
    localparam logic [ADDR_W-1:0] ADDR_SEQ = 12'h080;

    localparam logic [7:0] CMD_END = 8'h0F;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_RUN   = 2'd1,
        S_WAKE  = 2'd2,
        S_DELAY = 2'd3
    } seq_state_t;
endpackage

// File: rtl/lpseq_tick.sv
module lpseq_tick
    import lpseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/lpseq_regs.sv
module lpseq_regs
    import lpseq_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_valid,
    input  logic                      bus_write,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic                      busy,
    input  logic [DATA_W-1:0]         status_word,
    input  logic [FETCH_W-1:0]        fetch_idx,
    output logic [7:0]                fetch_byte,
    output logic [DIV_W-1:0]          cfg_div,
    output logic [DLY_FIELDS*DLY_W-1:0] dly_word,
    output logic                      ctl_en,
    output logic [IDX_W-1:0]          ctl_start
);
    localparam int WA_W = ADDR_W - 2;
    localparam logic [WA_W-1:0] SEQ_WA = ADDR_SEQ[ADDR_W-1:2];

    logic                 wr;
    logic                 wr_locked_ok;
    logic [WA_W-1:0]      word_addr;
    logic [DATA_W-1:0]    seq_words [SEQ_WORDS];
    logic [DIV_W-1:0]     cfg_q;
    logic [DLY_FIELDS*DLY_W-1:0] dly_q;
    logic                 en_q;
    logic [IDX_W-1:0]     start_q;
    logic [DATA_W-1:0]    rd_mux;
    logic                 seq_hit;

    assign wr           = bus_valid && bus_write;
    assign wr_locked_ok = wr && !busy;
    assign word_addr    = bus_addr[ADDR_W-1:2];
    assign seq_hit      = (word_addr >= SEQ_WA) && (word_addr < SEQ_WA + WA_W'(SEQ_WORDS));

    for (genvar g = 0; g < SEQ_WORDS; g++) begin : g_word
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wr_locked_ok && word_addr == SEQ_WA + WA_W'(g)) begin
                word_q <= bus_wdata;
            end
        end
        assign seq_words[g] = word_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            dly_q   <= '0;
            en_q    <= 1'b0;
            start_q <= '0;
        end else begin
            if (wr && bus_addr == ADDR_CFG) cfg_q <= bus_wdata[DIV_W-1:0];
            if (wr && bus_addr == ADDR_DLY) dly_q <= bus_wdata[DLY_FIELDS*DLY_W-1:0];
            if (wr_locked_ok && bus_addr == ADDR_CTL) begin
                en_q    <= bus_wdata[0];
                start_q <= bus_wdata[4 +: IDX_W];
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        if (seq_hit) begin
            rd_mux = seq_words[word_addr[$clog2(SEQ_WORDS)-1:0]];
        end else begin
            unique case (bus_addr)
                ADDR_CFG: rd_mux = DATA_W'(cfg_q);
                ADDR_STS: rd_mux = status_word;
                ADDR_CTL: rd_mux = DATA_W'({start_q, 3'b000, en_q});
                ADDR_DLY: rd_mux = DATA_W'(dly_q);
                default:  rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_valid && !bus_write) begin
            bus_rdata <= rd_mux;
        end
    end

    assign fetch_byte = seq_words[fetch_idx[FETCH_W-1:2]][8*fetch_idx[1:0] +: 8];
    assign cfg_div    = cfg_q;
    assign dly_word   = dly_q;
    assign ctl_en     = en_q;
    assign ctl_start  = start_q;

    // R12
    ctl_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_valid && bus_write && bus_addr == ADDR_CTL)
        |=> ($stable(en_q) && $stable(start_q)));
endmodule

// File: rtl/lpseq_engine.sv
module lpseq_engine
    import lpseq_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ctl_en,
    input  logic [IDX_W-1:0]            ctl_start,
    input  logic [DLY_FIELDS*DLY_W-1:0] dly_word,
    input  logic                        tick,
    input  logic                        core_wfi,
    input  logic                        wake_irq,
    input  logic [7:0]                  fetch_byte,
    output logic [FETCH_W-1:0]          fetch_idx,
    output logic [CTRL_W-1:0]           lp_ctrl,
    output logic                        core_hold,
    output logic                        busy,
    output logic                        waiting,
    output logic                        err,
    output logic [IDX_W-1:0]            cur_idx
);
    seq_state_t        st, nxt;
    logic              wfi_q;
    logic              wfi_rise;
    logic              start_ok;
    logic              over;
    logic              is_end;
    logic [2:0]        dsel;
    logic [2:0]        dsel_q;
    logic [DLY_W-1:0]  dly_val;
    logic [DLY_W-1:0]  dcnt;
    logic [4:0]        dly_pos;

    assign wfi_rise  = core_wfi && !wfi_q;
    assign start_ok  = wfi_rise && ctl_en;
    assign over      = cur_idx >= IDX_W'(SEQ_BYTES);
    assign fetch_idx = cur_idx[FETCH_W-1:0];
    assign is_end    = fetch_byte == CMD_END;
    assign dsel      = fetch_byte[6:4];
    assign dly_pos   = {dsel - 3'd1, 2'b00};
    assign dly_val   = dly_word[dly_pos +: DLY_W];
    assign busy      = st != S_IDLE;
    assign waiting   = st == S_WAKE;

    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE:  if (start_ok) nxt = S_RUN;
            S_RUN: begin
                if (tick) begin
                    if (over || is_end)      nxt = S_IDLE;
                    else if (fetch_byte[7])  nxt = S_WAKE;
                    else if (dsel != 3'd0)   nxt = S_DELAY;
                end
            end
            S_WAKE:  if (wake_irq) nxt = (dsel_q != 3'd0) ? S_DELAY : S_RUN;
            S_DELAY: if (tick && dcnt <= DLY_W'(1)) nxt = S_RUN;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wfi_q     <= 1'b0;
            cur_idx   <= '0;
            lp_ctrl   <= '0;
            core_hold <= 1'b0;
            err       <= 1'b0;
            dsel_q    <= '0;
            dcnt      <= '0;
        end else begin
            wfi_q <= core_wfi;
            unique case (st)
                S_IDLE: begin
                    if (start_ok) begin
                        cur_idx   <= ctl_start;
                        err       <= 1'b0;
                        core_hold <= 1'b1;
                    end
                end
                S_RUN: begin
                    if (tick) begin
                        if (over) begin
                            err       <= 1'b1;
                            core_hold <= 1'b0;
                            lp_ctrl   <= '0;
                        end else if (is_end) begin
                            core_hold <= 1'b0;
                            lp_ctrl   <= '0;
                        end else begin
                            lp_ctrl <= fetch_byte[CTRL_W-1:0];
                            cur_idx <= cur_idx + 1'b1;
                            dsel_q  <= dsel;
                            dcnt    <= dly_val;
                        end
                    end
                end
                S_WAKE: begin
                end
                S_DELAY: begin
                    if (tick && dcnt > DLY_W'(1)) dcnt <= dcnt - 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    // R1
    disabled_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && wfi_rise && !ctl_en) |=> (st == S_IDLE && !core_hold));
    // R6
    level_no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && core_wfi && wfi_q) |=> (st == S_IDLE));
    // R4
    end_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RUN && tick && !over && is_end) |=> (!core_hold && lp_ctrl == '0 && st == S_IDLE));
    // R7
    wake_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WAKE && !wake_irq) |=> (st == S_WAKE && $stable(lp_ctrl) && core_hold));
    // R11
    overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RUN && tick && over) |=> (err && !core_hold && lp_ctrl == '0));
endmodule

// File: rtl/lp_sequencer.sv
module lp_sequencer
    import lpseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              core_wfi,
    input  logic              wake_irq,
    output logic [3:0]        lp_ctrl,
    output logic              core_hold
);
    logic                        busy;
    logic                        waiting;
    logic                        err;
    logic [IDX_W-1:0]            cur_idx;
    logic [DATA_W-1:0]           status_word;
    logic [FETCH_W-1:0]          fetch_idx;
    logic [7:0]                  fetch_byte;
    logic [DIV_W-1:0]            cfg_div;
    logic [DLY_FIELDS*DLY_W-1:0] dly_word;
    logic                        ctl_en;
    logic [IDX_W-1:0]            ctl_start;
    logic                        tick;

    assign status_word = DATA_W'({err, waiting, busy, 1'b0, cur_idx});

    lpseq_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_valid   (bus_valid),
        .bus_write   (bus_write),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .busy        (busy),
        .status_word (status_word),
        .fetch_idx   (fetch_idx),
        .fetch_byte  (fetch_byte),
        .cfg_div     (cfg_div),
        .dly_word    (dly_word),
        .ctl_en      (ctl_en),
        .ctl_start   (ctl_start)
    );

    lpseq_tick u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .div   (cfg_div),
        .tick  (tick)
    );

    lpseq_engine u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_en     (ctl_en),
        .ctl_start  (ctl_start),
        .dly_word   (dly_word),
        .tick       (tick),
        .core_wfi   (core_wfi),
        .wake_irq   (wake_irq),
        .fetch_byte (fetch_byte),
        .fetch_idx  (fetch_idx),
        .lp_ctrl    (lp_ctrl),
        .core_hold  (core_hold),
        .busy       (busy),
        .waiting    (waiting),
        .err        (err),
        .cur_idx    (cur_idx)
    );
endmodule

// File: tb/sim_lp_sequencer.sv
module sim_lp_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        core_wfi = 1'b0;
    logic        wake_irq = 1'b0;
    logic [3:0]  lp_ctrl;
    logic        core_hold;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [3:0] exp_q[$];
    logic [3:0] prev_lp = 4'd0;
    string sb_req = "R3";

    always #4 clk = ~clk;

    lp_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_wfi(core_wfi), .wake_irq(wake_irq), .lp_ctrl(lp_ctrl), .core_hold(core_hold)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor: each change of lp_ctrl is compared with the next queued value
    always @(negedge clk) begin
        if (rst_n && lp_ctrl !== prev_lp) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL %s unexpected lp_ctrl actual=%h expected=none", sb_req, lp_ctrl);
            end else begin
                logic [3:0] e;
                e = exp_q.pop_front();
                if (lp_ctrl !== e) begin
                    failures++;
                    $display("FAIL %s lp_ctrl actual=%h expected=%h", sb_req, lp_ctrl, e);
                end
            end
            prev_lp = lp_ctrl;
        end
    end

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_lp(input logic [3:0] v, output int cyc);
        cyc = 0;
        while (lp_ctrl !== v && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic wait_release();
        for (int i = 0; i < 2000 && core_hold; i++) @(negedge clk);
    endtask

    task automatic pulse_wfi();
        @(negedge clk); core_wfi = 1'b1;
        @(negedge clk); core_wfi = 1'b0;
    endtask

    initial begin
        logic [31:0] d;
        int cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R10 reset status", 32'(lp_ctrl) | (32'(core_hold) << 4), 32'h0);
        bus_rd(12'h00C, d); chk("R10 status after reset", d, 32'h0);
        bus_rd(12'h030, d); chk("R2 control after reset", d, 32'h0);

        // register access
        bus_wr(12'h030, 32'hFFFF_FFFF);
        bus_rd(12'h030, d); chk("R2 control stored bits", d, 32'h0000_07F1);
        bus_wr(12'h034, 32'h0000_0023);
        bus_rd(12'h034, d); chk("R13 delay readback", d, 32'h0000_0023);
        bus_rd(12'h200, d); chk("R13 unmapped reads zero", d, 32'h0);
        // programs: A at 0 = 01 83 0F ; B at 3 = 04 AC 06 0F ; C at 24 has no end
        bus_wr(12'h080, 32'h040F_8301);
        bus_wr(12'h084, 32'h000F_06AC);
        bus_wr(12'h098, 32'h0102_0304);
        bus_wr(12'h09C, 32'h0E0D_0C0B);
        bus_rd(12'h084, d); chk("R3 store word readback", d, 32'h000F_06AC);

        // R1: disabled
        bus_wr(12'h030, 32'h0000_0000);
        sb_req = "R1";
        pulse_wfi();
        repeat (20) @(negedge clk);
        chk("R1 disabled keeps core running", 32'(core_hold), 32'h0);
        bus_rd(12'h00C, d); chk("R1 disabled not busy", d, 32'h0);

        // program A: wake stall
        bus_wr(12'h030, 32'h0000_0001);
        sb_req = "R7";
        exp_q.push_back(4'h1); exp_q.push_back(4'h3); exp_q.push_back(4'h0);
        @(negedge clk); core_wfi = 1'b1;
        wait_lp(4'h3, cyc);
        repeat (15) @(negedge clk);
        chk("R7 stalled output", 32'(lp_ctrl), 32'h3);
        chk("R7 core held while stalled", 32'(core_hold), 32'h1);
        bus_rd(12'h00C, d); chk("R10 status while waiting", d, 32'h0000_0302);
        @(negedge clk); wake_irq = 1'b1;
        @(negedge clk); wake_irq = 1'b0;
        wait_release();
        repeat (2) @(negedge clk);
        chk("R4 released after end marker", 32'(core_hold), 32'h0);
        bus_rd(12'h00C, d); chk("R4 idle index on end marker", d, 32'h0000_0002);
        // R6: level held high
        sb_req = "R6";
        repeat (20) @(negedge clk);
        chk("R6 no retrigger on level", 32'(core_hold), 32'h0);
        chk("R6 queue drained", 32'(exp_q.size()), 32'h0);
        core_wfi = 1'b0;

        // program B: mid-word start, divider 2, wake then delay field 2
        bus_wr(12'h008, 32'h0000_0002);
        bus_wr(12'h030, 32'h0000_0031);
        sb_req = "R5";
        exp_q.push_back(4'h4); exp_q.push_back(4'hC); exp_q.push_back(4'h6); exp_q.push_back(4'h0);
        pulse_wfi();
        wait_lp(4'h4, cyc);
        wait_lp(4'hC, cyc);
        chk("R9 step spacing with divider 2", 32'(cyc), 32'd3);
        bus_wr(12'h030, 32'h0000_0000);
        bus_wr(12'h080, 32'hFFFF_FFFF);
        repeat (5) @(negedge clk);
        @(negedge clk); wake_irq = 1'b1;
        @(negedge clk); wake_irq = 1'b0;
        wait_lp(4'h6, cyc);
        checks++;
        if (cyc < 5 || cyc > 12) begin
            failures++;
            $display("FAIL R8 delay cycles actual=%0d expected=5..12", cyc);
        end
        wait_release();
        repeat (2) @(negedge clk);
        chk("R5 queue drained", 32'(exp_q.size()), 32'h0);
        bus_rd(12'h030, d); chk("R12 control write ignored while busy", d, 32'h0000_0031);
        bus_rd(12'h080, d); chk("R12 store write ignored while busy", d, 32'h040F_8301);

        // program C: overrun
        bus_wr(12'h008, 32'h0000_0000);
        bus_wr(12'h030, 32'h0000_0181);
        sb_req = "R11";
        exp_q.push_back(4'h4); exp_q.push_back(4'h3); exp_q.push_back(4'h2); exp_q.push_back(4'h1);
        exp_q.push_back(4'hB); exp_q.push_back(4'hC); exp_q.push_back(4'hD); exp_q.push_back(4'hE);
        exp_q.push_back(4'h0);
        pulse_wfi();
        wait_release();
        repeat (3) @(negedge clk);
        chk("R11 queue drained", 32'(exp_q.size()), 32'h0);
        chk("R11 core released", 32'(core_hold), 32'h0);
        bus_rd(12'h00C, d); chk("R11 error status", d, 32'h0000_0420);

        // start index beyond the store
        bus_wr(12'h030, 32'h0000_0281);
        sb_req = "R2";
        pulse_wfi();
        repeat (10) @(negedge clk);
        chk("R2 out-of-range start releases", 32'(core_hold), 32'h0);
        bus_rd(12'h00C, d); chk("R11 out-of-range start error", d, 32'h0000_0428);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule